// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for a four-beat burst. A strobe captures a base address. On later cycles the block walks the two low address bits through the four positions of the aligned group that holds that base. The upper address bits stay at the captured value for the whole burst.

Two orders are available. The linear order counts upward modulo four from the starting position. The interleaved order XORs the starting position with a beat count of 0 to 3. The order is chosen by a static select input, which is captured only while reset is asserted.

Each cycle with the active-low advance input low steps the burst by one beat. A cycle with it high holds the current address, which gives a wait state. After the fourth beat the sequence wraps back to the start. A new strobe on either strobe input aborts the running burst and restarts it from the new base.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears its state, so `word_addr` reads 0 after that edge.
- R2: A rising edge with `strobe_a` or `strobe_b` high captures `base_addr`. From the next cycle, `word_addr` equals the captured value exactly, so the first beat is the external address. Either strobe alone is enough.
- R3: With `mode_sel` low captured at reset (linear order), beat k (k = 0..3) has low bits equal to (start + k) mod 4.
- R4: With `mode_sel` high captured at reset (interleaved order), beat k has low bits equal to start XOR k.
- R5: A rising edge with no strobe and `adv_n` high leaves `word_addr` unchanged, which gives a wait state.
- R6: A rising edge with no strobe and `adv_n` low moves to the next beat. After the fourth beat, the next advance returns to the starting address.
- R7: Bits above bit 1 of `word_addr` change only when a strobe loads a new base.
- R8: A strobe in the middle of a burst abandons the remaining beats and restarts at beat 0 of the new base.
- R9: `mode_sel` is sampled only while `rst` is high. Changes to it after reset have no effect on the order.
- R10: When a strobe and `adv_n` low occur on the same edge, the load wins and the first beat is the new base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also the window in which the order select is captured |
| mode_sel | input | 1 | Order select: 0 selects linear, 1 selects interleaved |
| strobe_a | input | 1 | Active-high address strobe, first source |
| strobe_b | input | 1 | Active-high address strobe, second source |
| base_addr | input | ADDR_W | Word address captured by a strobe |
| adv_n | input | 1 | Active-low beat advance; high inserts a wait state |
| word_addr | output | ADDR_W | Current burst word address |

## Verification
The bench sweeps every start position in both orders and across many upper-address values. It adds wait states in a pattern that shifts from burst to burst. A design that swaps the two orders, or ignores carries into bit 1, produces wrong beats for starts 01 and 11. A design that leaks a carry upward corrupts the upper bits at the wrap point. A design that counts on wait cycles runs ahead of the expected sequence. The bench also restarts bursts mid-way, with a strobe and an advance on the same edge, and toggles the order select after reset. These steps catch a design that keeps the old beat count, lets the advance beat the load, or follows the live select pin.

// File: rtl/bag_pkg.sv
package bag_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } burst_order_e;

    typedef struct packed {
        beat_t start;
        beat_t count;
    } burst_pos_t;

    function automatic beat_t beat_offset(beat_t start, beat_t count, burst_order_e ord);
        beat_t r;
        if (ord == ORDER_XOR) r = start ^ count;
        else                  r = start + count;
        return r;
    endfunction

endpackage

// File: rtl/bag_order_latch.sv
module bag_order_latch
    import bag_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_sel,
    output burst_order_e order
);
    always_ff @(posedge clk) begin
        if (rst) order <= mode_sel ? ORDER_XOR : ORDER_LINEAR;
    end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr
    import bag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  advance,
    output beat_t count
);
    always_ff @(posedge clk) begin
        if (rst)          count <= '0;
        else if (load)    count <= '0;
        else if (advance) count <= count + beat_t'(1);
    end
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
    import bag_pkg::*;
(
    input  burst_pos_t   pos,
    input  burst_order_e order,
    output beat_t        low
);
    always_comb low = beat_offset(pos.start, pos.count, order);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              strobe_a,
    input  logic              strobe_b,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              adv_n,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic            load;
    logic            advance;
    logic [HI_W-1:0] base_hi;
    beat_t           start_q;
    beat_t           count_q;
    beat_t           low;
    burst_order_e    order_q;
    burst_pos_t      pos;

    assign load    = strobe_a | strobe_b;
    assign advance = ~adv_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi <= '0;
            start_q <= '0;
        end else if (load) begin
            base_hi <= base_addr[ADDR_W-1:BEAT_W];
            start_q <= base_addr[BEAT_W-1:0];
        end
    end

    bag_order_latch u_order (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .order    (order_q)
    );

    bag_beat_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .advance (advance),
        .count   (count_q)
    );

    assign pos.start = start_q;
    assign pos.count = count_q;

    bag_order_map u_map (
        .pos   (pos),
        .order (order_q),
        .low   (low)
    );

    assign word_addr = {base_hi, low};

endmodule

// File: rtl/bag_checker.sv
module bag_checker
    import bag_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe_a,
    input logic              strobe_b,
    input logic              adv_n,
    input logic [ADDR_W-1:0] base_addr,
    input logic [ADDR_W-1:0] word_addr,
    input burst_order_e      order_q
);
    logic ld;
    assign ld = strobe_a | strobe_b;

    a_r2_load_base: assert property (@(posedge clk) disable iff (rst)
        ld |=> word_addr == $past(base_addr));

    a_r5_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (!ld && adv_n) |=> $stable(word_addr));

    a_r6_advance_moves: assert property (@(posedge clk) disable iff (rst)
        (!ld && !adv_n) |=> word_addr != $past(word_addr));

    a_r7_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        !ld |=> word_addr[ADDR_W-1:BEAT_W] == $past(word_addr[ADDR_W-1:BEAT_W]));

    a_r9_order_frozen: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(order_q));
endmodule

bind burst_addr_gen bag_checker #(.ADDR_W(ADDR_W)) u_bag_checker (
    .clk       (clk),
    .rst       (rst),
    .strobe_a  (strobe_a),
    .strobe_b  (strobe_b),
    .adv_n     (adv_n),
    .base_addr (base_addr),
    .word_addr (word_addr),
    .order_q   (order_q)
);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          mode_sel;
    logic          strobe_a;
    logic          strobe_b;
    logic [AW-1:0] base_addr;
    logic          adv_n;
    logic [AW-1:0] word_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
        .clk       (clk),
        .rst       (rst),
        .mode_sel  (mode_sel),
        .strobe_a  (strobe_a),
        .strobe_b  (strobe_b),
        .base_addr (base_addr),
        .adv_n     (adv_n),
        .word_addr (word_addr)
    );

    function automatic logic [1:0] exp_low(int s, int k, bit ilv);
        int v;
        v = ilv ? (s ^ k) : ((s + k) % 4);
        return 2'(v);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [AW-1:0] exp);
        n_chk++;
        if (word_addr !== exp) begin
            n_bad++;
            $display("FAIL %s: word_addr=%h expected=%h", req, word_addr, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_reset(bit m);
        @(negedge clk);
        rst = 1'b1; mode_sel = m; strobe_a = 0; strobe_b = 0; adv_n = 1; base_addr = '0;
        step(); step();
        check("R1 reset", '0);
        @(negedge clk);
        rst = 1'b0;
        mode_sel = ~m;            // R9: later changes must be ignored
    endtask

    task automatic load(logic [AW-1:0] b, bit use_b, bit adv);
        @(negedge clk);
        base_addr = b; strobe_a = ~use_b; strobe_b = use_b; adv_n = ~adv;
        step();
        check(adv ? "R10 load beats advance" : "R2 load base", b);
        @(negedge clk);
        strobe_a = 0; strobe_b = 0; base_addr = ~b;
    endtask

    task automatic sweep(bit ilv);
        for (int up = 0; up < (1 << (AW - 2)); up++) begin
            for (int s = 0; s < 4; s++) begin
                int k;
                load(AW'((up << 2) | s), s[0], 1'b0);
                k = 0;
                for (int c = 0; c < 10; c++) begin
                    bit adv;
                    adv = ((up + s + c) % 3) != 0;
                    adv_n = ~adv;
                    step();
                    if (adv) k = (k + 1) % 4;
                    // R3/R4 order, R5 hold, R6 wrap, R7 upper bits, R9 mode frozen
                    check(ilv ? "R4/R5/R6/R7/R9 interleaved" : "R3/R5/R6/R7/R9 linear",
                          AW'((up << 2) | exp_low(s, k, ilv)));
                    @(negedge clk);
                end
                adv_n = 1'b1;
            end
        end
    endtask

    task automatic interrupt(bit ilv);
        load(8'hA5, 1'b0, 1'b0);
        adv_n = 1'b0; step(); @(negedge clk); step();
        check("R8 pre-interrupt beat2", {6'h29, exp_low(1, 2, ilv)});
        load(8'h3E, 1'b1, 1'b1);  // R8 + R10
        adv_n = 1'b0; step();
        check("R8 restart beat1", {6'h0F, exp_low(2, 1, ilv)});
        @(negedge clk); adv_n = 1'b1;
    endtask

    initial begin
        rst = 1; mode_sel = 0; strobe_a = 0; strobe_b = 0; adv_n = 1; base_addr = '0;
        do_reset(1'b0);
        sweep(1'b0);
        interrupt(1'b0);
        do_reset(1'b1);
        sweep(1'b1);
        interrupt(1'b1);
        done = 1;
        summary();
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete");
            summary();
        end
    end
endmodule